// File: doc/BRIEF.md
# ECP Reverse-Channel Receiver with Run-Length Expansion

This block is the host side of an IEEE 1284 ECP port when the peripheral sends data back to the host. A transfer is started with a byte count. On the first request after reset, or after the mode has been left, the block first performs the post-negotiation setup step. If the port still faces forward, it then reverses the bus. After that it takes peripheral cycles one at a time, with a four-signal interlock on nAck and nAutoFd. Each cycle is either a data cycle or a command cycle, and the Busy line tells the two apart.

Command bytes are decoded inline. Channel addresses are dropped. A run count makes the next data byte appear on the output several times, so one bus cycle can produce many stream bytes. When a request ends partway through a run, the repeats that were not delivered are kept in the block. The next request delivers them first, before it takes any further bus cycle.

Output bytes leave on a valid/ready stream. When the stream consumer stalls, the bus handshake stops with it, so no byte is lost. The end of each request is reported with a one-cycle done pulse, the number of bytes delivered, and an error flag. The status inputs pass through a parameterised synchronizer. Every time limit is counted in ticks of an external timebase strobe.

Top module: `ecp_rev_rx`

## Requirements
- R1: While reset is held and directly after it is released: the four host control outputs are high, bus_rev is 0, m_valid is 0 and done is 0.
- R2: On the first request after reset or after a mode exit, the block drives hs_autofd_n low with bus_rev still 0. It then waits up to RESP_TICKS ticks for pp_perror to go high. If the wait runs out, the request ends with done, done_err=1 and done_count=0.
- R3: When the port is forward, the block sets bus_rev=1 and drives hs_autofd_n low. After SETUP_TICKS ticks it drives hs_init_n low, with hs_strobe_n and hs_selin_n high. It then waits up to RESP_TICKS ticks for pp_perror to go low. If that wait runs out, the request ends with done_err=1. hs_init_n is never low while bus_rev is 0.
- R4: A peripheral cycle begins when pp_nack goes low. If pp_nack stays high for IDLE_TICKS ticks, the request ends normally with done_err=0, and done_count holds the number of bytes delivered so far.
- R5: A cycle with pp_busy=1 is a data cycle. Its pp_data byte is delivered once on m_data.
- R6: A cycle with pp_busy=0 and pp_data bit 7 = 1 is a channel address. It delivers nothing and leaves the run state unchanged.
- R7: A cycle with pp_busy=0 and pp_data bit 7 = 0 loads pp_data[6:0] as a run count N. The next data byte is delivered 1+N times in total. N=0 gives a single copy.
- R8: Repeats are capped by the bytes still owed to the current request. Repeats not yet delivered are delivered at the start of the next request, before any bus cycle is taken.
- R9: After a cycle has been sampled, and after its byte has been accepted for a data cycle, hs_autofd_n goes high. The block then waits up to RESP_TICKS ticks for pp_nack to go high and then drives hs_autofd_n low again. If that wait runs out, the request ends with done_err=1.
- R10: While m_valid=1 and m_ready=0, m_valid stays 1, m_data stays stable and hs_autofd_n stays low.
- R11: A request ends with a one-cycle done pulse once done_count equals req_count, with done_err=0. A request for zero bytes ends at once with done_count=0.
- R12: A mode_exit pulse while the block is idle clears the stored run state. It also returns bus_rev to 0 and all host control outputs to high. The next request repeats the R2 setup step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase strobe; all time limits count these |
| start | input | 1 | Starts a request when the block is idle |
| req_count | input | CNT_W | Number of bytes requested |
| mode_exit | input | 1 | Leaves the reverse mode when the block is idle |
| pp_data | input | 8 | Peripheral data bus |
| pp_nack | input | 1 | Peripheral nAck status line |
| pp_busy | input | 1 | Peripheral Busy status line (1 = data cycle) |
| pp_perror | input | 1 | Peripheral PError status line |
| hs_autofd_n | output | 1 | Host nAutoFd line |
| hs_init_n | output | 1 | Host nInit line |
| hs_strobe_n | output | 1 | Host nStrobe line, held high |
| hs_selin_n | output | 1 | Host nSelectIn line, held high |
| bus_rev | output | 1 | Data bus direction, 1 = peripheral drives |
| m_valid | output | 1 | Output byte valid |
| m_data | output | 8 | Output byte |
| m_ready | input | 1 | Consumer accepts the byte |
| done | output | 1 | One-cycle pulse at the end of a request |
| done_count | output | CNT_W | Bytes delivered by the last request |
| done_err | output | 1 | Last request ended on a handshake or setup timeout |

## Verification
The hardest state to reach is a run that is split across two requests. The run count must be larger than what is left of the request, and the second request must then be served entirely from the stored repeats. To reach it, the stimulus sends a run count of five followed by one data byte against a request for three bytes. It then issues a second request for three bytes with the peripheral's cycle queue empty. A done pulse that arrives quickly with three copies shows that no bus cycle was taken. The timeout paths are reached by a bench peripheral model whose PError and nAck responses can each be switched off.

// File: rtl/ecp_rx_pkg.sv
package ecp_rx_pkg;

   localparam int BYTE_W = 8;
   localparam int RUN_W  = BYTE_W - 1;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_PRIME,
      RX_TURN,
      RX_TURN_WAIT,
      RX_RUN,
      RX_ACK_LO,
      RX_EMIT,
      RX_ACK_HI
   } rx_state_e;

   function automatic logic is_wait(input rx_state_e s);
      return (s == RX_PRIME) || (s == RX_TURN) || (s == RX_TURN_WAIT) ||
             (s == RX_ACK_LO) || (s == RX_ACK_HI);
   endfunction

endpackage

// File: rtl/ecp_in_sync.sv
module ecp_in_sync #(
   parameter int          W       = 11,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_pipe
         logic [W-1:0] pipe_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
            end else begin
               pipe_q[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            end
         end
         assign q = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/ecp_wait_timer.sv
module ecp_wait_timer #(
   parameter int TW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   input  logic [TW-1:0] limit,
   output logic          expired
);

   logic [TW-1:0] cnt_q;

   assign expired = tick && (cnt_q == limit - TW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr)    cnt_q <= '0;
      else if (tick)   cnt_q <= cnt_q + TW'(1);
   end

   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> (cnt_q < limit));

endmodule

// File: rtl/ecp_rle_store.sv
module ecp_rle_store #(
   parameter int RUN_W  = 7,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              cmd_ld,
   input  logic [RUN_W-1:0]  cmd_val,
   input  logic              data_ld,
   input  logic [BYTE_W-1:0] data_val,
   input  logic              take,
   output logic              rep_pend,
   output logic [BYTE_W-1:0] rep_byte
);

   logic [RUN_W-1:0]  left_q;
   logic              armed_q;
   logic [BYTE_W-1:0] byte_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q  <= '0;
         armed_q <= 1'b0;
         byte_q  <= '0;
      end else if (clr) begin
         left_q  <= '0;
         armed_q <= 1'b0;
         byte_q  <= '0;
      end else if (cmd_ld) begin
         left_q  <= cmd_val;
         armed_q <= 1'b1;
      end else if (data_ld && armed_q) begin
         byte_q  <= data_val;
         armed_q <= 1'b0;
      end else if (take) begin
         left_q  <= left_q - RUN_W'(1);
      end
   end

   assign rep_pend = (left_q != '0) && !armed_q;
   assign rep_byte = byte_q;

   // R8
   take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> rep_pend);

endmodule

// File: rtl/ecp_rx_ctrl.sv
module ecp_rx_ctrl
   import ecp_rx_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int TW      = 11,
   parameter int IDLE_T  = 2000,
   parameter int RESP_T  = 6,
   parameter int SETUP_T = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  req_count,
   input  logic              mode_exit,
   input  logic [BYTE_W-1:0] bus_q,
   input  logic              nack_q,
   input  logic              busy_q,
   input  logic              perror_q,
   input  logic              expired,
   output logic              tmr_clr,
   output logic [TW-1:0]     tmr_limit,
   output logic              rle_clr,
   output logic              cmd_ld,
   output logic              data_ld,
   output logic              take,
   input  logic              rep_pend,
   input  logic [BYTE_W-1:0] rep_byte,
   output logic              m_valid,
   output logic [BYTE_W-1:0] m_data,
   input  logic              m_ready,
   output logic              autofd_n,
   output logic              init_n,
   output logic              bus_rev,
   output logic              done,
   output logic [CNT_W-1:0]  done_count,
   output logic              done_err
);

   localparam logic [TW-1:0] LIM_IDLE  = TW'(IDLE_T);
   localparam logic [TW-1:0] LIM_RESP  = TW'(RESP_T);
   localparam logic [TW-1:0] LIM_SETUP = TW'(SETUP_T);

   rx_state_e         st_q, st_d;
   logic              autofd_q, autofd_d, init_q, init_d, rev_q, rev_d;
   logic              primed_q, primed_d, done_q, done_d, err_q, err_d;
   logic [CNT_W-1:0]  rem_q, rem_d, got_q, got_d;
   logic [BYTE_W-1:0] cap_q, cap_d;

   always_comb begin
      st_d     = st_q;
      autofd_d = autofd_q;
      init_d   = init_q;
      rev_d    = rev_q;
      primed_d = primed_q;
      rem_d    = rem_q;
      got_d    = got_q;
      cap_d    = cap_q;
      err_d    = err_q;
      done_d   = 1'b0;
      rle_clr  = 1'b0;
      cmd_ld   = 1'b0;
      data_ld  = 1'b0;
      take     = 1'b0;
      unique case (st_q)
         RX_IDLE: begin
            if (mode_exit) begin
               rle_clr  = 1'b1;
               rev_d    = 1'b0;
               autofd_d = 1'b1;
               init_d   = 1'b1;
               primed_d = 1'b0;
            end else if (start) begin
               rem_d = req_count;
               got_d = '0;
               err_d = 1'b0;
               if (!primed_q) begin
                  autofd_d = 1'b0;
                  st_d     = RX_PRIME;
               end else if (!rev_q) begin
                  rev_d    = 1'b1;
                  autofd_d = 1'b0;
                  st_d     = RX_TURN;
               end else begin
                  st_d = RX_RUN;
               end
            end
         end
         RX_PRIME: begin
            if (perror_q) begin
               primed_d = 1'b1;
               if (!rev_q) begin
                  rev_d    = 1'b1;
                  autofd_d = 1'b0;
                  st_d     = RX_TURN;
               end else begin
                  st_d = RX_RUN;
               end
            end else if (expired) begin
               done_d = 1'b1;
               err_d  = 1'b1;
               st_d   = RX_IDLE;
            end
         end
         RX_TURN: begin
            if (expired) begin
               init_d = 1'b0;
               st_d   = RX_TURN_WAIT;
            end
         end
         RX_TURN_WAIT: begin
            if (!perror_q) begin
               st_d = RX_RUN;
            end else if (expired) begin
               done_d = 1'b1;
               err_d  = 1'b1;
               st_d   = RX_IDLE;
            end
         end
         RX_RUN: begin
            if (rem_q == '0) begin
               done_d = 1'b1;
               st_d   = RX_IDLE;
            end else if (rep_pend) begin
               if (m_ready) begin
                  take  = 1'b1;
                  rem_d = rem_q - CNT_W'(1);
                  got_d = got_q + CNT_W'(1);
               end
            end else begin
               st_d = RX_ACK_LO;
            end
         end
         RX_ACK_LO: begin
            if (!nack_q) begin
               if (busy_q) begin
                  cap_d   = bus_q;
                  data_ld = 1'b1;
                  st_d    = RX_EMIT;
               end else begin
                  cmd_ld   = !bus_q[BYTE_W-1];
                  autofd_d = 1'b1;
                  st_d     = RX_ACK_HI;
               end
            end else if (expired) begin
               done_d = 1'b1;
               st_d   = RX_IDLE;
            end
         end
         RX_EMIT: begin
            if (m_ready) begin
               rem_d    = rem_q - CNT_W'(1);
               got_d    = got_q + CNT_W'(1);
               autofd_d = 1'b1;
               st_d     = RX_ACK_HI;
            end
         end
         RX_ACK_HI: begin
            if (nack_q) begin
               autofd_d = 1'b0;
               st_d     = RX_RUN;
            end else if (expired) begin
               done_d = 1'b1;
               err_d  = 1'b1;
               st_d   = RX_IDLE;
            end
         end
         default: st_d = RX_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= RX_IDLE;
         autofd_q <= 1'b1;
         init_q   <= 1'b1;
         rev_q    <= 1'b0;
         primed_q <= 1'b0;
         rem_q    <= '0;
         got_q    <= '0;
         cap_q    <= '0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         st_q     <= st_d;
         autofd_q <= autofd_d;
         init_q   <= init_d;
         rev_q    <= rev_d;
         primed_q <= primed_d;
         rem_q    <= rem_d;
         got_q    <= got_d;
         cap_q    <= cap_d;
         done_q   <= done_d;
         err_q    <= err_d;
      end
   end

   always_comb begin
      unique case (st_q)
         RX_ACK_LO: tmr_limit = LIM_IDLE;
         RX_TURN:   tmr_limit = LIM_SETUP;
         default:   tmr_limit = LIM_RESP;
      endcase
   end
   assign tmr_clr = (st_d != st_q) || !is_wait(st_q);

   assign m_valid    = (st_q == RX_EMIT) || ((st_q == RX_RUN) && (rem_q != '0) && rep_pend);
   assign m_data     = (st_q == RX_EMIT) ? cap_q : rep_byte;
   assign autofd_n   = autofd_q;
   assign init_n     = init_q;
   assign bus_rev    = rev_q;
   assign done       = done_q;
   assign done_count = got_q;
   assign done_err   = err_q;

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
   // R10
   stall_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> !autofd_n);
   // R3
   dir_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rev |-> init_n);
   // R11
   count_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q != RX_IDLE) && ($past(st_q) != RX_IDLE)) |->
      $stable({1'b0, rem_q} + {1'b0, got_q}));
   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx #(
   parameter int CNT_W       = 16,
   parameter int IDLE_TICKS  = 2000,
   parameter int RESP_TICKS  = 6,
   parameter int SETUP_TICKS = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start,
   input  logic [CNT_W-1:0] req_count,
   input  logic             mode_exit,
   input  logic [7:0]       pp_data,
   input  logic             pp_nack,
   input  logic             pp_busy,
   input  logic             pp_perror,
   output logic             hs_autofd_n,
   output logic             hs_init_n,
   output logic             hs_strobe_n,
   output logic             hs_selin_n,
   output logic             bus_rev,
   output logic             m_valid,
   output logic [7:0]       m_data,
   input  logic             m_ready,
   output logic             done,
   output logic [CNT_W-1:0] done_count,
   output logic             done_err
);
   import ecp_rx_pkg::*;

   localparam int MAX_T = (IDLE_TICKS > RESP_TICKS) ? IDLE_TICKS : RESP_TICKS;
   localparam int TW    = $clog2(MAX_T + 1) + 1;
   localparam int SW    = BYTE_W + 3;
   localparam logic [SW-1:0] SYNC_RST = {1'b1, 2'b00, {BYTE_W{1'b0}}};

   generate
      if (RESP_TICKS < 1 || SETUP_TICKS < 1 || IDLE_TICKS < RESP_TICKS) begin : g_bad_times
         $error("ecp_rev_rx: tick limits must be >= 1 and IDLE_TICKS >= RESP_TICKS");
      end
      if (CNT_W < 1 || SYNC_STAGES < 0) begin : g_bad_widths
         $error("ecp_rev_rx: CNT_W must be >= 1 and SYNC_STAGES >= 0");
      end
   endgenerate

   logic [SW-1:0]     st_raw, st_sync;
   logic [BYTE_W-1:0] bus_q;
   logic              nack_q, busy_q, perror_q;
   logic              tmr_clr, expired;
   logic [TW-1:0]     tmr_limit;
   logic              rle_clr, cmd_ld, data_ld, take, rep_pend;
   logic [BYTE_W-1:0] rep_byte;

   assign st_raw = {pp_nack, pp_busy, pp_perror, pp_data};
   assign {nack_q, busy_q, perror_q, bus_q} = st_sync;

   ecp_in_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(st_raw), .q(st_sync));

   ecp_wait_timer #(.TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick),
      .limit(tmr_limit), .expired(expired));

   ecp_rle_store #(.RUN_W(RUN_W), .BYTE_W(BYTE_W)) u_rle (
      .clk(clk), .rst_n(rst_n), .clr(rle_clr), .cmd_ld(cmd_ld),
      .cmd_val(bus_q[RUN_W-1:0]), .data_ld(data_ld), .data_val(bus_q),
      .take(take), .rep_pend(rep_pend), .rep_byte(rep_byte));

   ecp_rx_ctrl #(.CNT_W(CNT_W), .TW(TW), .IDLE_T(IDLE_TICKS),
                 .RESP_T(RESP_TICKS), .SETUP_T(SETUP_TICKS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .req_count(req_count),
      .mode_exit(mode_exit), .bus_q(bus_q), .nack_q(nack_q), .busy_q(busy_q),
      .perror_q(perror_q), .expired(expired), .tmr_clr(tmr_clr),
      .tmr_limit(tmr_limit), .rle_clr(rle_clr), .cmd_ld(cmd_ld),
      .data_ld(data_ld), .take(take), .rep_pend(rep_pend), .rep_byte(rep_byte),
      .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready),
      .autofd_n(hs_autofd_n), .init_n(hs_init_n), .bus_rev(bus_rev),
      .done(done), .done_count(done_count), .done_err(done_err));

   assign hs_strobe_n = 1'b1;
   assign hs_selin_n  = 1'b1;

endmodule

// File: tb/tb_ecp_rev_rx.sv
module tb_ecp_rev_rx;

   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 2;
   localparam int CNT_W      = 16;
   localparam int NV         = 12;
   localparam logic [8:0] VEC [NV] = '{
      9'h13C, 9'h085, 9'h15A, 9'h002, 9'h1E7, 9'h101,
      9'h000, 9'h199, 9'h090, 9'h004, 9'h142, 9'h1FF};

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0, mode_exit = 1'b0;
   logic [CNT_W-1:0] req_count = '0;
   logic [7:0] pp_data;
   logic pp_nack, pp_busy, pp_perror;
   logic hs_autofd_n, hs_init_n, hs_strobe_n, hs_selin_n, bus_rev;
   logic m_valid, m_ready = 1'b1, done, done_err;
   logic [7:0] m_data;
   logic [CNT_W-1:0] done_count;

   int vecs = 0, miss = 0;
   logic [8:0] pq [64];
   int ph = 0, pt = 0, p_st = 0, tick_cnt = 0;
   bit pe_hi_ok = 1, pe_lo_ok = 1, ack_stuck = 0;
   logic [7:0] out_buf [64];
   int n_out = 0;
   logic [7:0] exp_buf [64];
   int n_exp;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      tick_cnt = (tick_cnt + 1) % TICK_DIV;
      tick = (tick_cnt == 0);
   end

   ecp_rev_rx #(.CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .req_count(req_count),
      .mode_exit(mode_exit), .pp_data(pp_data), .pp_nack(pp_nack), .pp_busy(pp_busy),
      .pp_perror(pp_perror), .hs_autofd_n(hs_autofd_n), .hs_init_n(hs_init_n),
      .hs_strobe_n(hs_strobe_n), .hs_selin_n(hs_selin_n), .bus_rev(bus_rev),
      .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready), .done(done),
      .done_count(done_count), .done_err(done_err));

   // peripheral model
   initial begin
      pp_nack = 1'b1; pp_busy = 1'b0; pp_perror = 1'b0; pp_data = 8'h00;
      forever begin
         @(negedge clk);
         if (!hs_init_n) begin
            if (pe_lo_ok) pp_perror = 1'b0;
         end else if (!hs_autofd_n && pe_hi_ok) begin
            pp_perror = 1'b1;
         end
         case (p_st)
            0: if (ph < pt && bus_rev && !hs_init_n && !hs_autofd_n) begin
                  {pp_busy, pp_data} = pq[ph];
                  pp_nack = 1'b0;
                  p_st = 1;
               end
            1: if (hs_autofd_n && !ack_stuck) begin
                  pp_nack = 1'b1;
                  p_st = 2;
               end
            default: if (!hs_autofd_n) begin
                  ph++;
                  p_st = 0;
               end
         endcase
      end
   end

   // stream collector: accept happens at the next rising edge
   always @(negedge clk) begin
      if (rst_n && m_valid && m_ready) begin
         out_buf[n_out] = m_data;
         n_out++;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      vecs++;
      if (!ok) begin
         miss++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(input logic busy, input logic [7:0] d);
      pq[pt] = {busy, d};
      pt++;
   endtask

   task automatic pulse_start(input int count);
      req_count = CNT_W'(count);
      n_out = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic wait_done(output int cyc);
      cyc = 0;
      while (done !== 1'b1) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic pulse_exit();
      @(negedge clk) mode_exit = 1'b1;
      @(negedge clk) mode_exit = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miss++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end

   initial begin
      int cyc;
      int run, rep;
      bit armed;
      // R1 reset state
      repeat (3) @(negedge clk);
      chk(hs_autofd_n && hs_init_n && hs_strobe_n && hs_selin_n && !bus_rev && !m_valid && !done,
          "R1 reset outputs", {hs_autofd_n, hs_init_n, bus_rev, m_valid, done}, 5'b11000);
      rst_n = 1'b1;
      @(negedge clk);
      chk(hs_autofd_n && hs_init_n && !bus_rev && !m_valid && !done,
          "R1 after release", {hs_autofd_n, hs_init_n, bus_rev, m_valid, done}, 5'b11000);

      // table walk: build peripheral queue and expected stream
      n_exp = 0; run = 0; rep = 0; armed = 0;
      for (int i = 0; i < NV; i++) begin
         push(VEC[i][8], VEC[i][7:0]);
         if (VEC[i][8]) begin
            exp_buf[n_exp] = VEC[i][7:0]; n_exp++;
            if (armed) begin
               for (int k = 0; k < run; k++) begin exp_buf[n_exp] = VEC[i][7:0]; n_exp++; end
               armed = 0; run = 0;
            end
         end else if (!VEC[i][7]) begin
            run = VEC[i][6:0]; armed = 1;
         end
      end
      pulse_start(n_exp);
      chk(!hs_autofd_n && !bus_rev, "R2 setup drive", {hs_autofd_n, bus_rev}, 2'b00);
      while (hs_init_n) @(negedge clk);
      chk(bus_rev && !hs_autofd_n && hs_strobe_n && hs_selin_n, "R3 turnaround pins",
          {bus_rev, hs_autofd_n, hs_strobe_n, hs_selin_n}, 4'b1011);
      wait_done(cyc);
      chk(done_count == CNT_W'(n_exp) && !done_err, "R11 table count", done_count, n_exp);
      for (int i = 0; i < n_exp; i++)
         chk(i < n_out && out_buf[i] == exp_buf[i], "R5 R6 R7 stream byte", out_buf[i], exp_buf[i]);
      chk(n_out == n_exp, "R7 byte total", n_out, n_exp);

      // R11 zero request
      pulse_start(0);
      wait_done(cyc);
      chk(done_count == 0 && !done_err && cyc <= 4, "R11 zero count", cyc, 0);

      // R8 run split across requests
      push(1'b0, 8'h05); push(1'b1, 8'hA5);
      pulse_start(3);
      wait_done(cyc);
      chk(done_count == 3 && n_out == 3 && out_buf[0] == 8'hA5 && out_buf[2] == 8'hA5,
          "R8 capped run", done_count, 3);
      pulse_start(3);
      wait_done(cyc);
      chk(done_count == 3 && !done_err && cyc < 40, "R8 carried repeats no bus cycle", cyc, 3);
      chk(n_out == 3 && out_buf[0] == 8'hA5 && out_buf[2] == 8'hA5, "R8 carried bytes", out_buf[2], 8'hA5);

      // R4 idle timeout
      push(1'b1, 8'h10); push(1'b1, 8'h20);
      pulse_start(5);
      wait_done(cyc);
      chk(done_count == 2 && !done_err, "R4 idle timeout count", done_count, 2);
      chk(out_buf[0] == 8'h10 && out_buf[1] == 8'h20, "R4 bytes before timeout", out_buf[1], 8'h20);

      // R10 stall
      m_ready = 1'b0;
      push(1'b1, 8'h77);
      pulse_start(1);
      while (!m_valid) @(negedge clk);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk(m_valid && m_data == 8'h77 && !hs_autofd_n, "R10 stall hold", m_data, 8'h77);
      end
      m_ready = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(hs_autofd_n, "R9 autofd high after accept", hs_autofd_n, 1);
      wait_done(cyc);
      chk(done_count == 1 && out_buf[0] == 8'h77, "R10 byte after stall", out_buf[0], 8'h77);

      // R12 mode exit clears run state
      push(1'b0, 8'h04); push(1'b1, 8'h11);
      pulse_start(1);
      wait_done(cyc);
      chk(done_count == 1 && out_buf[0] == 8'h11, "R12 pre-exit byte", out_buf[0], 8'h11);
      pulse_exit();
      @(negedge clk);
      chk(hs_autofd_n && hs_init_n && !bus_rev, "R12 pins after exit",
          {hs_autofd_n, hs_init_n, bus_rev}, 3'b110);
      push(1'b1, 8'h22); push(1'b1, 8'h33);
      pulse_start(2);
      chk(!hs_autofd_n && !bus_rev, "R12 setup repeated", {hs_autofd_n, bus_rev}, 2'b00);
      wait_done(cyc);
      chk(done_count == 2 && out_buf[0] == 8'h22 && out_buf[1] == 8'h33,
          "R12 no stale repeats", out_buf[0], 8'h22);

      // R9 handshake timeout
      ack_stuck = 1;
      push(1'b1, 8'h31);
      pulse_start(2);
      wait_done(cyc);
      chk(done_err && done_count == 1, "R9 ack timeout", {done_err, done_count[7:0]}, 9'h101);
      ack_stuck = 0;

      // R2 setup timeout
      pulse_exit();
      pe_hi_ok = 0;
      pulse_start(1);
      wait_done(cyc);
      chk(done_err && done_count == 0 && !bus_rev, "R2 setup timeout", {done_err, bus_rev}, 2'b10);

      // R3 turnaround timeout
      pe_hi_ok = 1; pe_lo_ok = 0;
      pulse_start(1);
      wait_done(cyc);
      chk(done_err && done_count == 0 && bus_rev, "R3 turnaround timeout", {done_err, bus_rev}, 2'b11);

      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end

endmodule